// File: doc/BRIEF.md
# Disk Controller Read-ID Sequencer

This block runs the read-ID operation of a floppy-style disk controller. A host writes a two-byte command through a byte-wide port. The sequencer then waits a fixed pre-processing interval and watches a data-separator handshake for the next sector address field. It captures the track, head, sector and size-code bytes of that field, raises an interrupt and presents a seven-byte result, which the host reads one byte per read strobe.

The search has three possible endings, and each one has its own status encoding. It succeeds when an address field is reported. It times out when a second index pulse arrives with no address field. It is aborted when the host writes the port while the command is executing. The sequencer never steps the head, so the drive position is untouched. An opcode the sequencer does not recognise produces a one-byte error result.

Top module: `rid_seq`

## Requirements
- R1: A first command byte is a valid read-ID opcode when bits 4:0 are 0x0A and bits 7 and 5 are 0. Bit 6 of that byte is driven on `mfm_mode` from the cycle after the byte is accepted. In the second byte, bit 2 is the head select and bits 1:0 are the drive select, and they are driven on `sel_head` and `sel_drive`.
- R2: `searching` rises exactly DLY_CYCLES clock cycles after the edge that accepts the second command byte. An address-field report (`sep_valid`) during that interval is ignored.
- R3: The result after a successful search holds: ST0 = {2'b00, 3'b000, head, drive}, ST1 = 0x00, ST2 = 0x00, and then the track, head, sector and size bytes of the first address field reported while `searching` is high.
- R4: An index pulse counter starts from zero when the search begins. On the second index pulse with no address field, the result is ST0 = {2'b01, 3'b000, head, drive}, ST1 = 0x01, ST2 = 0x00, and four zero ID bytes.
- R5: A host write while the sequencer waits out the delay or searches aborts the command. The result is ST0 = {2'b01, 3'b000, head, drive}, ST1 = 0x00, ST2 = 0x00, and four zero ID bytes.
- R6: When events arrive in the same cycle, a host write wins over an address-field report, and an address-field report wins over the terminating index pulse.
- R7: `irq` rises in the cycle after the execution phase ends, by success, timeout or abort. It clears on the first result-byte read.
- R8: The result bytes are read in the order ST0, ST1, ST2, track, head, sector, size. `rd_valid` stays high until the seventh read. After that the sequencer is idle and accepts a new command.
- R9: An invalid opcode gives a single result byte of 0x80 with no interrupt, and the sequencer is then idle.
- R10: Host writes during the result phase are ignored. `host_rdata` holds its value while no read is made, and the remaining bytes are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe for the command port |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe, consumes one result byte |
| host_rdata | output | 8 | Current result byte (zero when no result is pending) |
| rd_valid | output | 1 | A result byte is available |
| irq | output | 1 | Execution-complete interrupt |
| mfm_mode | output | 1 | Recording mode flag from the opcode |
| sel_head | output | 1 | Latched head select |
| sel_drive | output | 2 | Latched drive select |
| searching | output | 1 | Address-field search in progress |
| sep_valid | input | 1 | Separator reports an address field this cycle |
| sep_track | input | 8 | Reported track byte |
| sep_head | input | 8 | Reported head byte |
| sep_sector | input | 8 | Reported sector byte |
| sep_size | input | 8 | Reported size-code byte |
| index_pulse | input | 1 | One-cycle index pulse |

## Verification
The checker asserts the rules that hold on every cycle. The interrupt is only pending while a result is readable. Search and result phases never overlap. Every end of a search leads straight into the result phase. A read while the interrupt is pending clears it. The result byte holds steady between reads, and the drive and head selects stay fixed during a search. The bench scenarios are needed to show the exact delay length, the byte values for each of the three endings, the tie-break order between simultaneous events, the rejection of reports during the delay, and the invalid-opcode path.

// File: rtl/rid_pkg.sv
// Shared types and constants of the read-ID sequencer.
// Assumes: 8-bit host bytes, seven-byte result frame.
package rid_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_CMD2,
        S_DELAY,
        S_SEARCH,
        S_RESULT
    } rid_state_t;

    localparam int          RES_BYTES   = 7;
    localparam logic [4:0]  OPC_READ_ID = 5'h0A;
    localparam logic [1:0]  IC_NORMAL   = 2'b00;
    localparam logic [1:0]  IC_ABNORMAL = 2'b01;
    localparam logic [7:0]  ST0_INVALID = 8'h80;
    localparam logic [7:0]  ST1_NO_MARK = 8'h01;

    // Build status byte 0 from the interrupt code and the unit selects.
    function automatic logic [7:0] pack_st0(logic [1:0] ic, logic hd, logic [1:0] ds);
        return {ic, 3'b000, hd, ds};
    endfunction
endpackage

// File: rtl/rid_delay_timer.sv
// Delay-before-processing timer.
// Loads on start; while enabled, counts down and flags done in the
// DLY_CYCLES-th enabled cycle. Assumes DLY_CYCLES >= 1.
module rid_delay_timer #(
    parameter int DLY_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic en,
    output logic done
);
    localparam int CW = (DLY_CYCLES > 1) ? $clog2(DLY_CYCLES) : 1;

    logic [CW-1:0] cnt;

    // Load on start, count down while running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= CW'(DLY_CYCLES - 1);
        else if (en && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // Terminal count while running.
    assign done = en && (cnt == '0);
endmodule

// File: rtl/rid_index_watch.sv
// Index-pulse watchdog for the address-field search.
// Counts pulses while enabled, is cleared whenever disabled, and flags
// the pulse that reaches IDX_LIMIT. Assumes IDX_LIMIT >= 1.
module rid_index_watch #(
    parameter int IDX_LIMIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic pulse,
    output logic hit
);
    localparam int CW = $clog2(IDX_LIMIT + 1);

    logic [CW-1:0] cnt;

    // Count pulses during the search, restart from zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            cnt <= '0;
        else if (pulse)
            cnt <= cnt + 1'b1;
    end

    // Limit reached on this pulse.
    assign hit = en && pulse && (cnt == CW'(IDX_LIMIT - 1));
endmodule

// File: rtl/rid_result_file.sv
// Result byte store: loads a whole frame at once and returns the
// byte picked by the read index. Assumes load and read never overlap.
module rid_result_file
    import rid_pkg::*;
#(
    parameter int NBYTES = RES_BYTES
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load,
    input  logic [NBYTES-1:0][7:0]       load_bytes,
    input  logic [$clog2(NBYTES)-1:0]    sel,
    output logic [7:0]                   dout
);
    logic [NBYTES-1:0][7:0] mem;

    // One register per result byte.
    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[g] <= 8'h00;
            else if (load)
                mem[g] <= load_bytes[g];
        end
    end

    // Read mux.
    assign dout = mem[sel];
endmodule

// File: rtl/rid_seq.sv
// Read-ID command sequencer (top).
// Accepts a two-byte command, waits the pre-processing delay, searches
// for an address field, ends on success, index timeout or host abort,
// and hands back a result frame. Never issues head steps.
// Assumes one-cycle strobes on host_wr, host_rd, sep_valid, index_pulse.
module rid_seq
    import rid_pkg::*;
#(
    parameter int DLY_CYCLES = 16,
    parameter int IDX_LIMIT  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_wr,
    input  logic [7:0] host_wdata,
    input  logic       host_rd,
    output logic [7:0] host_rdata,
    output logic       rd_valid,
    output logic       irq,
    output logic       mfm_mode,
    output logic       sel_head,
    output logic [1:0] sel_drive,
    output logic       searching,
    input  logic       sep_valid,
    input  logic [7:0] sep_track,
    input  logic [7:0] sep_head,
    input  logic [7:0] sep_sector,
    input  logic [7:0] sep_size,
    input  logic       index_pulse
);
    localparam int PW = $clog2(RES_BYTES);

    rid_state_t                 state;
    logic [PW-1:0]              rptr;
    logic                       short_res;
    logic                       op_ok;
    logic                       dly_done;
    logic                       idx_hit;
    logic                       res_load;
    logic                       exec_end;
    logic [RES_BYTES-1:0][7:0]  res_bytes;
    logic [7:0]                 res_dout;

    assign op_ok = (host_wdata[4:0] == OPC_READ_ID) && !host_wdata[7] && !host_wdata[5];

    rid_delay_timer #(.DLY_CYCLES(DLY_CYCLES)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .start (state == S_CMD2 && host_wr),
        .en    (state == S_DELAY),
        .done  (dly_done)
    );

    rid_index_watch #(.IDX_LIMIT(IDX_LIMIT)) u_idx (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state == S_SEARCH),
        .pulse (index_pulse),
        .hit   (idx_hit)
    );

    // Pick the frame to load: abort over found over timeout.
    always_comb begin
        res_bytes = '0;
        res_load  = 1'b0;
        if (state == S_IDLE && host_wr && !op_ok) begin
            res_load     = 1'b1;
            res_bytes[0] = ST0_INVALID;
        end else if ((state == S_DELAY || state == S_SEARCH) && host_wr) begin
            res_load     = 1'b1;
            res_bytes[0] = pack_st0(IC_ABNORMAL, sel_head, sel_drive);
        end else if (state == S_SEARCH && sep_valid) begin
            res_load     = 1'b1;
            res_bytes[0] = pack_st0(IC_NORMAL, sel_head, sel_drive);
            res_bytes[3] = sep_track;
            res_bytes[4] = sep_head;
            res_bytes[5] = sep_sector;
            res_bytes[6] = sep_size;
        end else if (idx_hit) begin
            res_load     = 1'b1;
            res_bytes[0] = pack_st0(IC_ABNORMAL, sel_head, sel_drive);
            res_bytes[1] = ST1_NO_MARK;
        end
    end

    assign exec_end = res_load && (state != S_IDLE);

    rid_result_file #(.NBYTES(RES_BYTES)) u_res (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (res_load),
        .load_bytes (res_bytes),
        .sel        (rptr),
        .dout       (res_dout)
    );

    // Phase sequencing, command latching, interrupt and read pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            rptr      <= '0;
            short_res <= 1'b0;
            irq       <= 1'b0;
            mfm_mode  <= 1'b0;
            sel_head  <= 1'b0;
            sel_drive <= 2'b00;
        end else begin
            case (state)
                S_IDLE: if (host_wr) begin
                    mfm_mode <= host_wdata[6];
                    rptr     <= '0;
                    if (op_ok) begin
                        state <= S_CMD2;
                    end else begin
                        state     <= S_RESULT;
                        short_res <= 1'b1;
                    end
                end
                S_CMD2: if (host_wr) begin
                    sel_head  <= host_wdata[2];
                    sel_drive <= host_wdata[1:0];
                    state     <= S_DELAY;
                end
                S_DELAY, S_SEARCH: begin
                    if (exec_end) begin
                        state     <= S_RESULT;
                        short_res <= 1'b0;
                        rptr      <= '0;
                        irq       <= 1'b1;
                    end else if (state == S_DELAY && dly_done) begin
                        state <= S_SEARCH;
                    end
                end
                S_RESULT: if (host_rd) begin
                    irq <= 1'b0;
                    if (short_res || rptr == PW'(RES_BYTES - 1))
                        state <= S_IDLE;
                    else
                        rptr <= rptr + 1'b1;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign searching  = (state == S_SEARCH);
    assign rd_valid   = (state == S_RESULT);
    assign host_rdata = rd_valid ? res_dout : 8'h00;
endmodule

// File: rtl/rid_seq_chk.sv
// Port-level rule checker for rid_seq, attached with bind.
// Assumes the same single-cycle strobe conventions as the sequencer.
module rid_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_rd,
    input logic [7:0] host_rdata,
    input logic       rd_valid,
    input logic       irq,
    input logic       sel_head,
    input logic [1:0] sel_drive,
    input logic       searching
);
    // R7: a pending interrupt always has a readable result.
    a_r7_irq_with_result: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> rd_valid);

    // R7: reading while the interrupt is pending clears it.
    a_r7_irq_clears_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && host_rd) |=> !irq);

    // R8: search and result phases never overlap.
    a_r8_phase_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(searching && rd_valid));

    // R3/R4/R5: every end of a search goes straight to the result phase.
    a_r3_search_ends_in_result: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(searching) |-> rd_valid);

    // R10: the presented byte holds while no read is made.
    a_r10_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !host_rd) |=> $stable(host_rdata));

    // R1: unit selects stay fixed while searching.
    a_r1_selects_stable: assert property (@(posedge clk) disable iff (!rst_n)
        searching |=> ($stable(sel_drive) && $stable(sel_head)));
endmodule

bind rid_seq rid_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_rd    (host_rd),
    .host_rdata (host_rdata),
    .rd_valid   (rd_valid),
    .irq        (irq),
    .sel_head   (sel_head),
    .sel_drive  (sel_drive),
    .searching  (searching)
);

// File: tb/sim_rid_seq.sv
module sim_rid_seq;
    localparam int DLY = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic       host_rd = 1'b0;
    logic [7:0] host_rdata;
    logic       rd_valid, irq, mfm_mode, sel_head, searching;
    logic [1:0] sel_drive;
    logic       sep_valid = 1'b0;
    logic [7:0] sep_track = 8'h00, sep_head = 8'h00, sep_sector = 8'h00, sep_size = 8'h00;
    logic       index_pulse = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    rid_seq #(.DLY_CYCLES(DLY), .IDX_LIMIT(2)) u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_rdata(host_rdata), .rd_valid(rd_valid), .irq(irq),
        .mfm_mode(mfm_mode), .sel_head(sel_head), .sel_drive(sel_drive),
        .searching(searching), .sep_valid(sep_valid), .sep_track(sep_track),
        .sep_head(sep_head), .sep_sector(sep_sector), .sep_size(sep_size),
        .index_pulse(index_pulse)
    );

    // kind: 0 found, 1 index timeout, 2 abort
    function automatic logic [7:0] exp_res(int kind, int i, logic hd, logic [1:0] ds, logic [31:0] id);
        logic [7:0] st0;
        st0 = {(kind == 0) ? 2'b00 : 2'b01, 3'b000, hd, ds};
        case (i)
            0: return st0;
            1: return (kind == 1) ? 8'h01 : 8'h00;
            2: return 8'h00;
            default: return (kind == 0) ? id[8*(i-3) +: 8] : 8'h00;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] b);
        host_wr = 1'b1; host_wdata = b;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sep(logic [31:0] id);
        sep_valid = 1'b1;
        {sep_size, sep_sector, sep_head, sep_track} = id;
        @(negedge clk);
        sep_valid = 1'b0;
    endtask

    task automatic idx();
        index_pulse = 1'b1;
        @(negedge clk);
        index_pulse = 1'b0;
    endtask

    // Read and check a full seven-byte frame.
    task automatic read_frame(string req, int kind, logic hd, logic [1:0] ds, logic [31:0] id);
        check("R7 irq raised", irq, 1);
        for (int i = 0; i < 7; i++) begin
            check("R8 rd_valid", rd_valid, 1);
            check(req, host_rdata, exp_res(kind, i, hd, ds, id));
            host_rd = 1'b1;
            @(negedge clk);
            host_rd = 1'b0;
            if (i == 0) check("R7 irq cleared by first read", irq, 0);
        end
        check("R8 idle after frame", rd_valid, 0);
    endtask

    task automatic cmd(logic mfm, logic hd, logic [1:0] ds);
        wr({1'b0, mfm, 1'b0, 5'h0A});
        wr({5'b0, hd, ds});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] id;
        void'($urandom(32'h1D5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("reset irq", irq, 0);
        check("reset rd_valid", rd_valid, 0);
        check("reset searching", searching, 0);

        // R1 + R2: selects, mode flag, exact delay, reports during delay ignored
        cmd(1'b1, 1'b1, 2'b10);
        check("R1 mfm_mode", mfm_mode, 1);
        check("R1 sel_head", sel_head, 1);
        check("R1 sel_drive", sel_drive, 2'b10);
        check("R2 not searching at delay start", searching, 0);
        sep(32'hDEADBEEF);
        idle(DLY - 2);
        check("R2 not searching before delay ends", searching, 0);
        idle(1);
        check("R2 searching after delay", searching, 1);
        check("R2 early report ignored", rd_valid, 0);
        sep(32'h02030405);
        read_frame("R3 found frame", 0, 1'b1, 2'b10, 32'h02030405);

        // R4: timeout on second index pulse; pulse in delay is not counted
        cmd(1'b0, 1'b0, 2'b01);
        check("R1 mfm cleared", mfm_mode, 0);
        idx();
        idle(DLY - 1);
        idx();
        idle(3);
        check("R4 one pulse in search keeps searching", searching, 1);
        idx();
        read_frame("R4 timeout frame", 1, 1'b0, 2'b01, 0);

        // R6: abort beats a report in the same cycle
        cmd(1'b0, 1'b1, 2'b11);
        idle(DLY);
        sep_valid = 1'b1; {sep_size, sep_sector, sep_head, sep_track} = 32'h11223344;
        wr(8'h55);
        sep_valid = 1'b0;
        read_frame("R6 abort over report", 2, 1'b1, 2'b11, 0);

        // R6: report beats the terminating index pulse
        cmd(1'b0, 1'b0, 2'b00);
        idle(DLY);
        idx();
        index_pulse = 1'b1;
        sep(32'hA1B2C3D4);
        index_pulse = 1'b0;
        read_frame("R6 report over timeout", 0, 1'b0, 2'b00, 32'hA1B2C3D4);

        // R5: abort during the delay
        cmd(1'b1, 1'b0, 2'b10);
        idle(2);
        wr(8'h00);
        check("R5 abort leaves no search", searching, 0);
        read_frame("R5 abort in delay", 2, 1'b0, 2'b10, 0);

        // R9: invalid opcode, single byte, no irq
        wr(8'h2A);
        check("R9 result ready", rd_valid, 1);
        check("R9 no irq", irq, 0);
        check("R9 invalid code", host_rdata, 8'h80);
        host_rd = 1'b1; @(negedge clk); host_rd = 1'b0;
        check("R9 idle after one byte", rd_valid, 0);

        // R10: writes during the result phase are ignored
        cmd(1'b0, 1'b1, 2'b01);
        idle(DLY);
        sep(32'h0A0B0C0D);
        wr(8'hFF);
        check("R10 still in result", rd_valid, 1);
        read_frame("R10 frame intact", 0, 1'b1, 2'b01, 32'h0A0B0C0D);

        // Random mix of outcomes
        for (int n = 0; n < 40; n++) begin
            int kind;
            logic hd;
            logic [1:0] ds;
            kind = int'($urandom_range(0, 2));
            hd = 1'($urandom);
            ds = 2'($urandom);
            id = $urandom;
            cmd(1'($urandom), hd, ds);
            if ($urandom_range(0, 1) == 1) sep($urandom); else idle(1);
            idle(DLY - 1);
            check("R2 search begun", searching, 1);
            idle(int'($urandom_range(0, 4)));
            if (kind == 0) begin
                if ($urandom_range(0, 1) == 1) idx();
                idle(int'($urandom_range(0, 3)));
                sep(id);
                read_frame("R3 random found", 0, hd, ds, id);
            end else if (kind == 1) begin
                idx();
                idle(int'($urandom_range(0, 5)));
                idx();
                read_frame("R4 random timeout", 1, hd, ds, 0);
            end else begin
                wr(8'($urandom));
                read_frame("R5 random abort", 2, hd, ds, 0);
            end
        end

        done_flag = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule